// File: doc/BRIEF.md
# Split-Lane 16-bit Byte-Addressed Memory

This block is a 16-bit word memory built from two separate 8-bit storage banks. One bank holds the bytes at even byte addresses and the other holds the bytes at odd byte addresses. A requester presents a 24-bit byte address, an active-low select, an active-low read enable and two active-low byte write strobes. The even byte of each word travels on the upper half of the data bus (bits 15:8) and the odd byte on the lower half (bits 7:0), so the memory is big-endian within a word.

Both banks see the same word index, taken from the address with bit 0 dropped. An even address and the odd address right after it therefore name the same word. Which bytes change on a write depends only on the two strobes. A read always returns the whole word. The block answers only inside one fixed 1 MiB window, where the top address nibble equals 1 (0x100000 to 0x1FFFFF). The bank depth is a parameter so that simulation can use a small part of the window. Index bits above that depth are not decoded, so those addresses alias onto the same words.

Top module: `dbb_mem16`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `rvalid` is 0 and `rdata` is 0x0000.
- R2: When `cs_n`=0 and `oe_n`=0 with an address inside the window at a clock edge, then after that edge `rvalid`=1 and `rdata` holds the even-bank byte in bits 15:8 and the odd-bank byte in bits 7:0 of the addressed word.
- R3: Address bit 0 has no effect on which word is read or written: byte addresses 2k and 2k+1 reach the same word.
- R4: With only `hwr_n` low, a write stores `wdata[15:8]` into the even bank and leaves the odd byte of the word unchanged.
- R5: With only `lwr_n` low, a write stores `wdata[7:0]` into the odd bank and leaves the even byte of the word unchanged.
- R6: With both strobes low, a write stores all 16 bits of `wdata` into the word.
- R7: The window is hit only when `addr[23:20]` equals 4'b0001. Outside the window, strobes change nothing, and a read gives `rvalid`=0 and `rdata`=0x0000.
- R8: With `cs_n` high, strobes change nothing, and the next cycle shows `rvalid`=0 and `rdata`=0x0000.
- R9: With `oe_n` high, the next cycle shows `rvalid`=0 and `rdata`=0x0000, even inside the window.
- R10: A read and a write to the same word at the same edge return the contents from before that write.
- R11: Within the window, index bits above the bank depth (`addr[19:BANK_AW+1]`) are ignored, so such addresses alias onto the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 24 | Byte address |
| cs_n | input | 1 | Active-low select |
| oe_n | input | 1 | Active-low read enable |
| hwr_n | input | 1 | Active-low write strobe for the even (upper) byte lane |
| lwr_n | input | 1 | Active-low write strobe for the odd (lower) byte lane |
| wdata | input | 16 | Write data, even byte in 15:8 |
| rdata | output | 16 | Read word, valid one cycle after the request |
| rvalid | output | 1 | High when `rdata` carries a word read from the window |

## Verification
The memory is first filled with word writes whose two bytes differ at every index. Reading the words back from even addresses and then from odd addresses shows whether bit 0 is ignored and whether the lanes are swapped. Single-strobe writes that use a data value different from the old contents show whether one lane's strobe leaks into the other lane. Writes with a bad nibble, with the select high, or to an address that only differs in a high index bit show, in turn, whether the window decode, the select gating and the aliasing are correct. A read and a write to the same word at the same edge shows whether a read returns the old or the new contents.

// File: rtl/dbb_pkg.sv
package dbb_pkg;

    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 16;
    localparam int LANE_W  = 8;
    localparam int N_LANES = DATA_W / LANE_W;
    localparam int WIN_MSB = 23;
    localparam int WIN_LSB = 20;
    localparam logic [WIN_MSB-WIN_LSB:0] WIN_TAG = 4'h1;
    localparam int MAX_BANK_AW = WIN_LSB - 1;

    typedef enum logic [0:0] {
        LANE_EVEN = 1'b0,
        LANE_ODD  = 1'b1
    } lane_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              cs_n;
        logic              oe_n;
        logic              hwr_n;
        logic              lwr_n;
        logic [DATA_W-1:0] wdata;
    } mem_req_t;

    function automatic logic in_window(logic [ADDR_W-1:0] a);
        return a[WIN_MSB:WIN_LSB] == WIN_TAG;
    endfunction

    // even lane sits on the upper half of the word (big-endian)
    function automatic logic [LANE_W-1:0] lane_slice(logic [DATA_W-1:0] w, lane_e l);
        return (l == LANE_EVEN) ? w[DATA_W-1:LANE_W] : w[LANE_W-1:0];
    endfunction

    function automatic logic lane_strobe(mem_req_t r, lane_e l);
        return (l == LANE_EVEN) ? ~r.hwr_n : ~r.lwr_n;
    endfunction

endpackage

// File: rtl/dbb_decode.sv
module dbb_decode
    import dbb_pkg::*;
#(
    parameter int BANK_AW = 10
) (
    input  mem_req_t           req,
    output logic               hit,
    output logic               rd_en,
    output logic [N_LANES-1:0] lane_we,
    output logic [BANK_AW-1:0] idx
);
    logic unused_addr;

    // bit 0 selects a byte inside the word and is dropped; the bits above
    // the bank index only take part through the window compare
    assign unused_addr = ^req.addr;

    always_comb begin
        hit   = ~req.cs_n & in_window(req.addr);
        rd_en = hit & ~req.oe_n;
        idx   = req.addr[BANK_AW:1];
        for (int l = 0; l < N_LANES; l++) begin
            lane_we[l] = hit & lane_strobe(req, lane_e'(l));
        end
    end
endmodule

// File: rtl/dbb_bank.sv
module dbb_bank
    import dbb_pkg::*;
#(
    parameter int BANK_AW = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic               re,
    input  logic [BANK_AW-1:0] idx,
    input  logic [LANE_W-1:0]  wbyte,
    output logic [LANE_W-1:0]  rbyte
);
    localparam int DEPTH = 1 << BANK_AW;

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wbyte;
        end
    end

    // read samples the array before this edge's write lands
    always_ff @(posedge clk) begin
        if (rst) begin
            rbyte <= '0;
        end else if (re) begin
            rbyte <= mem[idx];
        end
    end

    // R4 / R5 / R6: a strobed lane holds the written byte afterwards
    a_r4_lane_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(idx)] == $past(wbyte));

    // R10: a read at a write edge returns the earlier byte
    a_r10_read_before_write: assert property (@(posedge clk) disable iff (rst)
        (re && we) |=> rbyte == $past(mem[idx]));
endmodule

// File: rtl/dbb_mem16.sv
module dbb_mem16
    import dbb_pkg::*;
#(
    parameter int BANK_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [23:0]       addr,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              hwr_n,
    input  logic              lwr_n,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              rvalid
);
    mem_req_t           req;
    logic               hit;
    logic               rd_en;
    logic [N_LANES-1:0] lane_we;
    logic [BANK_AW-1:0] idx;
    logic [LANE_W-1:0]  lane_q [N_LANES];
    logic [DATA_W-1:0]  word_q;
    logic               valid_q;

    initial begin
        if (BANK_AW < 1 || BANK_AW > MAX_BANK_AW) begin
            $error("BANK_AW out of range");
        end
    end

    assign req = '{addr: addr, cs_n: cs_n, oe_n: oe_n,
                   hwr_n: hwr_n, lwr_n: lwr_n, wdata: wdata};

    dbb_decode #(.BANK_AW(BANK_AW)) u_dec (
        .req     (req),
        .hit     (hit),
        .rd_en   (rd_en),
        .lane_we (lane_we),
        .idx     (idx)
    );

    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        dbb_bank #(.BANK_AW(BANK_AW)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (lane_we[l]),
            .re    (rd_en),
            .idx   (idx),
            .wbyte (lane_slice(req.wdata, lane_e'(l))),
            .rbyte (lane_q[l])
        );
    end

    assign word_q = {lane_q[LANE_EVEN], lane_q[LANE_ODD]};

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= rd_en;
        end
    end

    assign rvalid = valid_q;
    assign rdata  = valid_q ? word_q : '0;

    // R1: reset leaves the read port quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!rvalid && rdata == '0));

    // R2: valid data only follows a selected, enabled request
    a_r2_valid_has_cause: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> $past(!cs_n && !oe_n && in_window(addr)));

    // R7: outside the window nothing is read and no lane is written
    a_r7_window_read: assert property (@(posedge clk) disable iff (rst)
        !in_window(addr) |=> (!rvalid && rdata == '0));
    a_r7_window_write: assert property (@(posedge clk) disable iff (rst)
        !in_window(addr) |-> lane_we == '0);

    // R8: deselected port stays quiet
    a_r8_deselect: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!rvalid && rdata == '0));

    // R9: read enable high gives a zero word
    a_r9_oe_high: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> (!rvalid && rdata == '0));

    // R4 / R5: each strobe reaches only its own lane
    a_r4_even_strobe_only: assert property (@(posedge clk) disable iff (rst)
        hwr_n |-> !lane_we[LANE_EVEN]);
    a_r5_odd_strobe_only: assert property (@(posedge clk) disable iff (rst)
        lwr_n |-> !lane_we[LANE_ODD]);
endmodule

// File: tb/dbb_mem16_test.sv
module dbb_mem16_test;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    typedef struct {
        logic [15:0] d;
        logic        v;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] addr = '0;
    logic        cs_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        hwr_n = 1'b1;
    logic        lwr_n = 1'b1;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rvalid;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t sb[$];
    logic [7:0] ev_m [DEPTH];
    logic [7:0] od_m [DEPTH];

    always #2 clk = ~clk;

    dbb_mem16 #(.BANK_AW(AW)) uut (
        .clk(clk), .rst(rst), .addr(addr), .cs_n(cs_n), .oe_n(oe_n),
        .hwr_n(hwr_n), .lwr_n(lwr_n), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    task automatic check(input string tag, input logic [15:0] d, input logic v,
                         input logic [15:0] ed, input logic ev);
        checks++;
        if (d !== ed || v !== ev) begin
            errors++;
            $display("FAIL %s rdata=%h rvalid=%b expected rdata=%h rvalid=%b",
                     tag, d, v, ed, ev);
        end
    endtask

    // driver: one request per cycle, expectation computed from the model
    task automatic cyc(input logic [23:0] a, input logic c, input logic o,
                       input logic hw, input logic lw, input logic [15:0] wd,
                       input string tag);
        exp_t e;
        int   i;
        logic hit;
        @(negedge clk);
        addr = a; cs_n = c; oe_n = o; hwr_n = hw; lwr_n = lw; wdata = wd;
        hit = !c && (a[23:20] == 4'h1);
        i   = int'((a >> 1) & (DEPTH - 1));
        e.v = hit && !o;
        e.d = e.v ? {ev_m[i], od_m[i]} : 16'h0000;
        e.tag = tag;
        sb.push_back(e);
        if (hit && !hw) ev_m[i] = wd[15:8];
        if (hit && !lw) od_m[i] = wd[7:0];
    endtask

    // monitor: compare one cycle after each request
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, rdata, rvalid, e.d, e.v);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", rdata, rvalid, 16'h0000, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 after reset", rdata, rvalid, 16'h0000, 1'b0);

        // R6 fill every word with both strobes, R9 read enable held high
        for (int i = 0; i < DEPTH; i++) begin
            cyc(24'h100000 | 24'(i << 1), 0, 1, 0, 0,
                16'((i * 16'h0301) ^ 16'h5AC3), "R6/R9 fill");
        end
        // R2 read even addresses
        for (int i = 0; i < DEPTH; i++) begin
            cyc(24'h100000 | 24'(i << 1), 0, 0, 1, 1, 16'h0, "R2 read even");
        end
        // R3 odd addresses reach the same word
        for (int i = 0; i < DEPTH; i += 5) begin
            cyc(24'h100001 | 24'(i << 1), 0, 0, 1, 1, 16'h0, "R3 read odd");
        end
        // R4 upper lane only, via odd address too
        cyc(24'h100008, 0, 1, 0, 1, 16'hA1B2, "R4 hwr");
        cyc(24'h100009, 0, 0, 1, 1, 16'h0, "R4 readback");
        cyc(24'h100013, 0, 1, 0, 1, 16'hEE11, "R4/R3 hwr odd addr");
        cyc(24'h100012, 0, 0, 1, 1, 16'h0, "R4 readback2");
        // R5 lower lane only
        cyc(24'h10000A, 0, 1, 1, 0, 16'hC3D4, "R5 lwr");
        cyc(24'h10000A, 0, 0, 1, 1, 16'h0, "R5 readback");
        // R7 outside window: writes ignored, reads quiet
        cyc(24'h20000C, 0, 1, 0, 0, 16'hDEAD, "R7 write 0x2");
        cyc(24'h00000C, 0, 1, 0, 0, 16'hBEEF, "R7 write 0x0");
        cyc(24'h30000C, 0, 1, 0, 0, 16'hF00D, "R7 write 0x3");
        cyc(24'h20000C, 0, 0, 1, 1, 16'h0, "R7 read outside");
        cyc(24'h90000C, 0, 0, 1, 1, 16'h0, "R7 read outside high");
        cyc(24'h10000C, 0, 0, 1, 1, 16'h0, "R7 inside unchanged");
        // R8 deselected
        cyc(24'h10000E, 1, 0, 0, 0, 16'h1234, "R8 deselect write");
        cyc(24'h10000E, 0, 0, 1, 1, 16'h0, "R8 inside unchanged");
        // R9 read enable high inside window
        cyc(24'h10000E, 0, 1, 1, 1, 16'h0, "R9 oe high");
        // R10 read during write returns the old word
        cyc(24'h100010, 0, 0, 0, 0, 16'h7E57, "R10 read at write");
        cyc(24'h100010, 0, 0, 1, 1, 16'h0, "R10 new value");
        // R11 high index bits alias onto word 2
        cyc(24'h100004 | 24'(1 << (AW + 1)), 0, 1, 0, 0, 16'h4A11, "R11 alias write");
        cyc(24'h100004, 0, 0, 1, 1, 16'h0, "R11 base read");
        cyc(24'h1F0005, 0, 0, 1, 1, 16'h0, "R11 far alias read");

        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1; hwr_n = 1'b1; lwr_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule